// File: doc/BRIEF.md
# Phased Video/Control Parallel Deframer

This block sits behind the clock-recovery and line-decoding stages of a serial video receiver. Each recovered word arrives with a strobe and a phase flag. While the flag marks active video, the word is steered onto an 18-bit pixel bus and the data-enable output goes high. While the flag marks blanking, the word is decoded into a 9-bit control bus and data-enable goes low. The bus that is not being written keeps its last value.

In a control word, control bits 0 to 4 each arrive as three copies and are resolved by majority vote, so a single flipped copy is tolerated. Control bits 5 to 8 each arrive as a single copy.

A lock state machine runs on the local reference clock and has three states:
- HUNT: the link is counted for health.
- STRETCH: lock is asserted, but the output clock is held at its idle level and no words pass.
- RUN: words are accepted.

The transitions are:
- HUNT to STRETCH, after the lock count of consecutive healthy cycles.
- STRETCH to RUN, after the stretch count.
- Any state to HUNT, when the link becomes unhealthy.

A pin selects which edge of the output pixel clock the outputs are stable for. An output-enable and an active-low power-down switch the output drivers off. Power-down also drops lock.

Top module: `phased_deframer`

## Requirements
- R1: In RUN, a strobed word with phase flag 1 loads word bits [17:0] onto `video_o` and sets `de_o` to 1, visible after the clock edge that samples it.
- R2: In RUN, a strobed word with phase flag 0 loads the decoded control value onto `ctrl_o` and sets `de_o` to 0, visible after that edge.
- R3: Control bit i (i = 0..4) is the majority of word bits [3i+2:3i]. Control bit 5+j (j = 0..3) is word bit 15+j. Any single flipped copy within a triplet leaves the result unchanged.
- R4: A data-phase word leaves `ctrl_o` unchanged, and a control-phase word leaves `video_o` unchanged.
- R5: After reset, with a healthy link, `lock_o` rises after exactly LOCK_CNT (default 16385) consecutive healthy clock edges.
- R6: The link is unhealthy in any of these cases:
  - `flag_ok_i` is low;
  - `pwrdn_ni` is low;
  - MISS_LIMIT consecutive edges have passed with no strobe.

  Lock is cleared at the edge that sees an unhealthy link, and the count restarts from zero.
- R7: For the STRETCH_CYC edges after lock rises, the output clock stays at its idle level and strobed words are ignored.
- R8: The output clock marks each accepted word. With `edge_sel_i` = 1, `pclk_o` is 0 in the cycle after the update and 1 otherwise, so data is stable at its rising edge. With `edge_sel_i` = 0, the polarity is inverted.
- R9: While `out_en_i` or `pwrdn_ni` is low, `drive_oe_o` is 0 and every parallel, clock and lock output reads 0, with no clock delay. Clearing only `out_en_i` keeps the internal lock and data.
- R10: Words strobed before lock do not change `video_o`, `ctrl_o` or `de_o`.
- R11: After reset, the following outputs read 0: `video_o`, `ctrl_o`, `de_o`, `lock_o`. `pclk_o` is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_vld_i | input | 1 | Recovered-word strobe; at most one every other cycle |
| word_phase_i | input | 1 | 1 = video word, 0 = control word |
| word_i | input | 19 | Recovered word |
| flag_ok_i | input | 1 | Phase flag is being received |
| edge_sel_i | input | 1 | 1 = stable at rising edge, 0 = stable at falling edge |
| out_en_i | input | 1 | Output driver enable |
| pwrdn_ni | input | 1 | Active-low power-down |
| video_o | output | 18 | Pixel data |
| ctrl_o | output | 9 | Control data |
| de_o | output | 1 | Data-enable |
| pclk_o | output | 1 | Output pixel clock |
| lock_o | output | 1 | Link locked |
| drive_oe_o | output | 1 | Enable for the pad drivers |

## Verification
A lock counter that is off by even one count moves the `lock_o` rise by one cycle. The bench measures that rise edge by edge after reset and after each way of losing the link, so the error shows immediately.

A state machine stuck in STRETCH or HUNT shows up one cycle after the next strobe: the pixel or control bus fails to take the word. A vote or field error shows on `ctrl_o` one cycle after the control word is strobed. The bench sweeps every 9-bit control value with a rotating single-copy error, which exposes such an error.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } lock_state_t;

    // Two-of-three vote on one triplicated bit
    function automatic logic maj3(input logic [2:0] c);
        return (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
    endfunction

endpackage

// File: rtl/pf_link_monitor.sv
module pf_link_monitor #(
    parameter int MISS_LIMIT = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic word_vld_i,
    input  logic flag_ok_i,
    input  logic pwrdn_ni,
    output logic healthy_o
);
    localparam int MW = $clog2(MISS_LIMIT + 1);

    logic [MW-1:0] miss_q;

    // Cycles since the last recovered-word strobe, saturating
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            miss_q <= '0;
        end else if (word_vld_i) begin
            miss_q <= '0;
        end else if (miss_q != MW'(MISS_LIMIT)) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    assign healthy_o = flag_ok_i & pwrdn_ni & (miss_q != MW'(MISS_LIMIT));

endmodule

// File: rtl/pf_lock_fsm.sv
module pf_lock_fsm
    import pf_pkg::*;
#(
    parameter int LOCK_CNT    = 16385,
    parameter int STRETCH_CYC = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        healthy_i,
    output lock_state_t state_o,
    output logic        lock_o
);
    localparam int CW = $clog2(LOCK_CNT + 1);
    localparam int SW = $clog2(STRETCH_CYC + 1);

    lock_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sc_q;
    logic          lock_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (healthy_i && cnt_q == CW'(LOCK_CNT - 1)) state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (!healthy_i)                             state_d = ST_HUNT;
                else if (sc_q == SW'(STRETCH_CYC - 1))      state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!healthy_i)                             state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HUNT;
        else         state_q <= state_d;
    end

    // Counters and lock output
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            sc_q   <= '0;
            lock_q <= 1'b0;
        end else begin
            if (state_q == ST_HUNT && state_d == ST_HUNT && healthy_i) cnt_q <= cnt_q + 1'b1;
            else                                                       cnt_q <= '0;
            if (state_q == ST_STRETCH && state_d == ST_STRETCH)        sc_q  <= sc_q + 1'b1;
            else                                                       sc_q  <= '0;
            lock_q <= (state_d != ST_HUNT);
        end
    end

    assign state_o = state_q;
    assign lock_o  = lock_q;

endmodule

// File: rtl/pf_ctrl_vote.sv
module pf_ctrl_vote
    import pf_pkg::*;
#(
    parameter int CTL_W  = 9,
    parameter int VOTE_N = 5,
    parameter int RAW_W  = 3 * VOTE_N + (CTL_W - VOTE_N)
) (
    input  logic [RAW_W-1:0] raw_i,
    output logic [CTL_W-1:0] ctl_o
);
    localparam int VOTE_BITS = 3 * VOTE_N;
    localparam int SINGLE_N  = CTL_W - VOTE_N;

    for (genvar i = 0; i < VOTE_N; i++) begin : g_vote
        assign ctl_o[i] = maj3(raw_i[3*i +: 3]);
    end

    for (genvar j = 0; j < SINGLE_N; j++) begin : g_single
        assign ctl_o[VOTE_N + j] = raw_i[VOTE_BITS + j];
    end

endmodule

// File: rtl/pf_out_stage.sv
module pf_out_stage #(
    parameter int VID_W = 18,
    parameter int CTL_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             word_vld_i,
    input  logic             word_phase_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [VID_W-1:0] vid_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             de_o,
    output logic             pclk_raw_o
);
    logic             take;
    logic [VID_W-1:0] vid_q;
    logic [CTL_W-1:0] ctl_q;
    logic             de_q;
    logic             pclk_raw_q;

    assign take = run_i & word_vld_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vid_q      <= '0;
            ctl_q      <= '0;
            de_q       <= 1'b0;
            pclk_raw_q <= 1'b1;
        end else begin
            if (take) begin
                de_q <= word_phase_i;
                if (word_phase_i) vid_q <= vid_i;
                else              ctl_q <= ctl_i;
            end
            // Low for the cycle after an accepted word, idle high otherwise
            pclk_raw_q <= ~take;
        end
    end

    assign vid_o      = vid_q;
    assign ctl_o      = ctl_q;
    assign de_o       = de_q;
    assign pclk_raw_o = pclk_raw_q;

endmodule

// File: rtl/phased_deframer.sv
module phased_deframer
    import pf_pkg::*;
#(
    parameter int LOCK_CNT    = 16385,
    parameter int MISS_LIMIT  = 8,
    parameter int STRETCH_CYC = 2,
    parameter int VID_W       = 18,
    parameter int CTL_W       = 9,
    parameter int VOTE_N      = 5,
    parameter int RAW_W       = 3 * VOTE_N + (CTL_W - VOTE_N),
    parameter int WORD_W      = (VID_W > RAW_W) ? VID_W : RAW_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              word_vld_i,
    input  logic              word_phase_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              flag_ok_i,
    input  logic              edge_sel_i,
    input  logic              out_en_i,
    input  logic              pwrdn_ni,
    output logic [VID_W-1:0]  video_o,
    output logic [CTL_W-1:0]  ctrl_o,
    output logic              de_o,
    output logic              pclk_o,
    output logic              lock_o,
    output logic              drive_oe_o
);
    logic             healthy_w;
    lock_state_t      state_w;
    logic             lock_w;
    logic [CTL_W-1:0] ctl_dec_w;
    logic [VID_W-1:0] vid_w;
    logic [CTL_W-1:0] ctl_w;
    logic             de_w;
    logic             pclk_raw_w;
    logic             drv_en_w;

    pf_link_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .word_vld_i(word_vld_i),
        .flag_ok_i (flag_ok_i),
        .pwrdn_ni  (pwrdn_ni),
        .healthy_o (healthy_w)
    );

    pf_lock_fsm #(.LOCK_CNT(LOCK_CNT), .STRETCH_CYC(STRETCH_CYC)) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .healthy_i(healthy_w),
        .state_o  (state_w),
        .lock_o   (lock_w)
    );

    pf_ctrl_vote #(.CTL_W(CTL_W), .VOTE_N(VOTE_N), .RAW_W(RAW_W)) u_vote (
        .raw_i(word_i[RAW_W-1:0]),
        .ctl_o(ctl_dec_w)
    );

    pf_out_stage #(.VID_W(VID_W), .CTL_W(CTL_W)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (state_w == ST_RUN),
        .word_vld_i  (word_vld_i),
        .word_phase_i(word_phase_i),
        .vid_i       (word_i[VID_W-1:0]),
        .ctl_i       (ctl_dec_w),
        .vid_o       (vid_w),
        .ctl_o       (ctl_w),
        .de_o        (de_w),
        .pclk_raw_o  (pclk_raw_w)
    );

    // Driver gating toward the pad ring
    assign drv_en_w   = out_en_i & pwrdn_ni;
    assign drive_oe_o = drv_en_w;
    assign video_o    = drv_en_w ? vid_w : '0;
    assign ctrl_o     = drv_en_w ? ctl_w : '0;
    assign de_o       = drv_en_w & de_w;
    assign pclk_o     = drv_en_w & (pclk_raw_w ~^ edge_sel_i);
    assign lock_o     = drv_en_w & lock_w;

endmodule

// File: rtl/pf_chk.sv
module pf_chk
    import pf_pkg::*;
#(
    parameter int VID_W = 18,
    parameter int CTL_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             word_vld_i,
    input  logic             word_phase_i,
    input  logic             flag_ok_i,
    input  logic             out_en_i,
    input  logic             pwrdn_ni,
    input  lock_state_t      state_w,
    input  logic             lock_w,
    input  logic [VID_W-1:0] vid_w,
    input  logic [CTL_W-1:0] ctl_w,
    input  logic             de_w,
    input  logic             pclk_raw_w,
    input  logic             drive_oe_o,
    input  logic             lock_o
);
    // R1
    de_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_RUN && word_vld_i) |=> (de_w == $past(word_phase_i)));

    // R4
    vid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_RUN && word_vld_i && !word_phase_i) |=> $stable(vid_w));

    // R4
    ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_RUN && word_vld_i && word_phase_i) |=> $stable(ctl_w));

    // R6
    flag_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_ok_i |=> !lock_w);

    // R6
    pwr_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwrdn_ni |=> !lock_w);

    // R7
    stretch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_STRETCH) |-> (lock_w && pclk_raw_w));

    // R10
    hunt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_HUNT) |=> ($stable(vid_w) && $stable(ctl_w) && $stable(de_w)));

    // R9
    drive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(out_en_i && pwrdn_ni) |-> (!drive_oe_o && !lock_o));

endmodule

bind phased_deframer pf_chk #(.VID_W(VID_W), .CTL_W(CTL_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_vld_i  (word_vld_i),
    .word_phase_i(word_phase_i),
    .flag_ok_i   (flag_ok_i),
    .out_en_i    (out_en_i),
    .pwrdn_ni    (pwrdn_ni),
    .state_w     (state_w),
    .lock_w      (lock_w),
    .vid_w       (vid_w),
    .ctl_w       (ctl_w),
    .de_w        (de_w),
    .pclk_raw_w  (pclk_raw_w),
    .drive_oe_o  (drive_oe_o),
    .lock_o      (lock_o)
);

// File: tb/tb_phased_deframer.sv
module tb_phased_deframer;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK_N     = 16385;
    localparam int MISS_N     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0, phase = 1'b0, flag = 1'b1, esel = 1'b1, oe = 1'b1, pwr = 1'b1;
    logic [18:0] word = '0;
    logic [17:0] video;
    logic [8:0]  ctrl;
    logic        de, pclk, lock, drv;

    int nvec = 0, nfail = 0;
    logic [17:0] exp_vid = '0;
    logic [8:0]  exp_ctl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phased_deframer dut (
        .clk_i(clk), .rst_ni(rst_n), .word_vld_i(vld), .word_phase_i(phase),
        .word_i(word), .flag_ok_i(flag), .edge_sel_i(esel), .out_en_i(oe),
        .pwrdn_ni(pwr), .video_o(video), .ctrl_o(ctrl), .de_o(de),
        .pclk_o(pclk), .lock_o(lock), .drive_oe_o(drv)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [18:0] enc(input logic [8:0] c, input int t, input int pos);
        logic [18:0] w = '0;
        for (int i = 0; i < 5; i++) w[3*i +: 3] = {3{c[i]}};
        if (pos < 3) w[3*t + pos] = ~w[3*t + pos];
        for (int j = 0; j < 4; j++) w[15 + j] = c[5 + j];
        return w;
    endfunction

    // Strobes words every other cycle until lock shows; checks edge count (R5)
    task automatic wait_lock(input int exp_n, input string req);
        int n = 0;
        phase = 1'b1;
        word  = 19'h7FFFF;
        while (1) begin
            vld = (n % 2 == 0);
            tick();
            n++;
            if (lock || n > exp_n + 50) break;
        end
        vld = 1'b0;
        check(n == exp_n, req, n, exp_n);
    endtask

    task automatic send(input logic ph, input logic [18:0] w);
        vld = 1'b1; phase = ph; word = w;
        tick();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R5 watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R11 reset state
        check(video == 0 && ctrl == 0 && de == 0, "R11 buses", {video, de}, 0);
        check(lock == 0 && pclk == 1 && drv == 1, "R11 lock/pclk", {lock, pclk, drv}, 3'b011);
        rst_n = 1'b1;

        // R5 lock count; R10 words strobed during hunt ignored
        wait_lock(LOCK_N, "R5 first lock");
        check(video == 0 && de == 0, "R10 hunt words", {video, de}, 0);

        // R7 stretch: word ignored, clock idle
        send(1'b1, 19'h15555);
        check(video == 0 && pclk == 1, "R7 stretch 1", {video, pclk}, 1);
        vld = 1'b0; tick();
        check(video == 0 && pclk == 1, "R7 stretch 2", {video, pclk}, 1);

        // R1 R4 R8 data sweep
        for (int k = 0; k < 64; k++) begin
            logic [18:0] w = 19'((k * 4099 + 677) ^ (k << 12));
            send(1'b1, w);
            exp_vid = w[17:0];
            check(video == exp_vid && de == 1, "R1 data word", {video, de}, {exp_vid, 1'b1});
            check(ctrl == exp_ctl, "R4 ctrl held", ctrl, exp_ctl);
            check(pclk == 0, "R8 update phase", pclk, 0);
            vld = 1'b0; tick();
            check(pclk == 1, "R8 idle phase", pclk, 1);
        end

        // R2 R3 R4 control sweep, rotating single-copy error
        for (int p = 0; p < 512; p++) begin
            send(1'b0, enc(9'(p), p % 5, (p / 5) % 4));
            exp_ctl = 9'(p);
            check(ctrl == exp_ctl && de == 0, "R3 R2 control vote", {ctrl, de}, {exp_ctl, 1'b0});
            check(video == exp_vid, "R4 video held", video, exp_vid);
            vld = 1'b0; tick();
        end

        // R9 output enable only: outputs off, lock kept
        oe = 1'b0; #1;
        check(drv == 0 && lock == 0 && video == 0 && ctrl == 0 && pclk == 0, "R9 oe off",
              {drv, lock, pclk}, 0);
        oe = 1'b1; #1;
        check(lock == 1 && video == exp_vid && ctrl == exp_ctl, "R9 oe restore", lock, 1);

        // R6 flag loss
        tick();
        flag = 1'b0; tick();
        check(lock == 0, "R6 flag loss", lock, 0);
        flag = 1'b1;
        wait_lock(LOCK_N, "R6 relock after flag");
        tick(); tick();

        // R9 R6 power-down
        pwr = 1'b0; #1;
        check(drv == 0 && lock == 0 && de == 0 && video == 0, "R9 pwrdn off", {drv, lock}, 0);
        tick();
        pwr = 1'b1; #1;
        check(lock == 0 && drv == 1, "R6 pwrdn clears lock", lock, 0);
        check(video == exp_vid && ctrl == exp_ctl, "R9 data held", video, exp_vid);
        wait_lock(LOCK_N, "R6 relock after pwrdn");
        tick(); tick();

        // R6 recovered clock loss boundary
        send(1'b0, enc(9'h1A5, 0, 3));
        exp_ctl = 9'h1A5;
        vld = 1'b0;
        repeat (MISS_N) tick();
        check(lock == 1, "R6 miss limit not yet", lock, 1);
        tick();
        check(lock == 0, "R6 miss limit reached", lock, 0);
        wait_lock(LOCK_N + 1, "R6 relock after clock loss");
        tick(); tick();

        // R8 falling-edge selection
        esel = 1'b0; #1;
        check(pclk == 0, "R8 idle inverted", pclk, 0);
        send(1'b1, 19'h2AAAA);
        check(pclk == 1 && video == 18'h2AAAA, "R8 update inverted", pclk, 1);
        vld = 1'b0; tick();
        check(pclk == 0, "R8 idle after update", pclk, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule